// File: doc/BRIEF.md
# Weighted Hysteresis Threshold Gate

This block models one state-holding threshold element of a dual-rail, delay-insensitive logic style as clocked logic. Each of its single-bit inputs carries an integer weight fixed at elaboration. When the weights of the asserted inputs add up to at least the threshold, the output goes high. Once high, the output stays high for as long as any input is still asserted. It drops only when every input is low. While the output is low, a nonzero input set whose weight falls short of the threshold leaves it low.

The state sits in one register with a synchronous active-high reset, so the output changes one clock edge after the inputs. The top module is built by default as a four-input element with threshold three. The input on bit 0 weighs two and the other three inputs weigh one each. The same core takes any input count, weight vector and threshold through its parameters.

Top module: `hyst_wtgate`

## Requirements
- R1: While `rst` is high at a rising clock edge, `q` is 0 after that edge, whatever `din` holds.
- R2: `q` is registered. When the summed weight of the asserted `din` bits is at least `THRESH` at a rising edge, `q` is 1 after that edge, whatever its previous value.
- R3: In the default build, `din[0]` weighs 2 and `din[1]`, `din[2]`, `din[3]` weigh 1 each, with threshold 3. `din[0]` together with any one other input sets `q`.
- R4: In the default build, `din[1]`, `din[2]` and `din[3]` all high, with `din[0]` low, set `q`.
- R5: With `q` at 0, a nonzero `din` whose weight is below the threshold leaves `q` at 0.
- R6: With `q` at 1, any nonzero `din`, including one below the threshold, keeps `q` at 1.
- R7: `din` all zero at a rising edge, with `rst` low, makes `q` 0 after that edge. A set condition always wins over this clear condition.
- R8: `THRESH` lies between 1 and the sum of all weights, so the all-ones input always sets `q`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; state updates on the rising edge |
| rst | input | 1 | Synchronous active-high reset; clears the state to 0 |
| din | input | N | Gate inputs; bit i carries weight i of `WEIGHTS` |
| q | output | 1 | Registered state-holding gate output |

## Verification
Each result is due exactly one rising edge after the `din` value that causes it. This holds for set, hold, clear and reset alike, because the single state register is the only delay on the path. The bench changes `din` on a falling edge and reads `q` on the next falling edge, after one rising edge has passed, so every check lands in the cycle where the new value must already be present. History matters to this block, so each sub-threshold pattern is checked twice: once after the output was cleared, and once while the output was held high by an earlier set.

// File: rtl/hyst_wtgate_pkg.sv
package hyst_wtgate_pkg;
  // Next-state action chosen by the decision stage
  typedef enum logic [1:0] {
    ACT_HOLD = 2'd0,
    ACT_SET  = 2'd1,
    ACT_CLR  = 2'd2
  } gate_act_t;
endpackage

// File: rtl/wt_accum.sv
module wt_accum #(
  parameter int unsigned N = 4,
  parameter int unsigned WB = 4,
  parameter int unsigned SW = 5,
  parameter logic [N*WB-1:0] WEIGHTS = '0
) (
  input  logic [N-1:0]  din,
  output logic [SW-1:0] wsum
);
  logic [WB-1:0] terms [N];

  // Each asserted input contributes its own weight
  for (genvar i = 0; i < N; i++) begin : g_term
    assign terms[i] = din[i] ? WEIGHTS[i*WB +: WB] : '0;
  end

  always_comb begin
    wsum = '0;
    for (int i = 0; i < N; i++) begin
      wsum = wsum + SW'(terms[i]);
    end
  end
endmodule

// File: rtl/th_decide.sv
module th_decide
  import hyst_wtgate_pkg::*;
#(
  parameter int unsigned N = 4,
  parameter int unsigned SW = 5,
  parameter int unsigned THRESH = 3
) (
  input  logic [SW-1:0] wsum,
  input  logic [N-1:0]  din,
  output gate_act_t     act
);
  localparam logic [SW-1:0] THR = SW'(THRESH);

  // Set outranks clear; anything else keeps the stored state
  always_comb begin
    if (wsum >= THR)     act = ACT_SET;
    else if (din == '0)  act = ACT_CLR;
    else                 act = ACT_HOLD;
  end
endmodule

// File: rtl/hyst_state.sv
module hyst_state
  import hyst_wtgate_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  gate_act_t act,
  output logic      q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q <= 1'b0;
    end else begin
      case (act)
        ACT_SET: q <= 1'b1;
        ACT_CLR: q <= 1'b0;
        default: q <= q;
      endcase
    end
  end
endmodule

// File: rtl/hyst_wtgate.sv
module hyst_wtgate
  import hyst_wtgate_pkg::*;
#(
  parameter int unsigned N = 4,
  parameter int unsigned WB = 4,
  parameter int unsigned THRESH = 3,
  parameter logic [N*WB-1:0] WEIGHTS = {4'd1, 4'd1, 4'd1, 4'd2}
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] din,
  output logic         q
);
  localparam int unsigned MAX_SUM = N * ((1 << WB) - 1);
  localparam int unsigned SW = $clog2(MAX_SUM + 1);

  logic [SW-1:0] wsum;
  gate_act_t     act;

  wt_accum #(.N(N), .WB(WB), .SW(SW), .WEIGHTS(WEIGHTS)) u_accum (
    .din  (din),
    .wsum (wsum)
  );

  th_decide #(.N(N), .SW(SW), .THRESH(THRESH)) u_decide (
    .wsum (wsum),
    .din  (din),
    .act  (act)
  );

  hyst_state u_state (
    .clk (clk),
    .rst (rst),
    .act (act),
    .q   (q)
  );
endmodule

// File: rtl/hyst_wtgate_chk.sv
module hyst_wtgate_chk #(
  parameter int unsigned N = 4,
  parameter int unsigned WB = 4,
  parameter int unsigned THRESH = 3,
  parameter logic [N*WB-1:0] WEIGHTS = '0
) (
  input logic         clk,
  input logic         rst,
  input logic [N-1:0] din,
  input logic         q
);
  function automatic int total_w();
    int t = 0;
    for (int i = 0; i < N; i++) t += int'(WEIGHTS[i*WB +: WB]);
    return t;
  endfunction

  int ws;
  always_comb begin
    ws = 0;
    for (int i = 0; i < N; i++) begin
      if (din[i]) ws += int'(WEIGHTS[i*WB +: WB]);
    end
  end

  initial begin
    assert_thresh_range_R8: assert (THRESH >= 1 && int'(THRESH) <= total_w())
      else $error("threshold out of range");
  end

  assert_reset_R1: assert property (@(posedge clk) rst |=> !q);

  assert_set_R2: assert property (@(posedge clk) disable iff (rst)
    (ws >= int'(THRESH)) |=> q);

  assert_stay_low_R5: assert property (@(posedge clk) disable iff (rst)
    (!q && ws < int'(THRESH)) |=> !q);

  assert_hold_high_R6: assert property (@(posedge clk) disable iff (rst)
    (q && din != '0) |=> q);

  assert_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (din == '0) |=> !q);
endmodule

bind hyst_wtgate hyst_wtgate_chk #(
  .N(N), .WB(WB), .THRESH(THRESH), .WEIGHTS(WEIGHTS)
) u_chk (
  .clk (clk),
  .rst (rst),
  .din (din),
  .q   (q)
);

// File: tb/sim_hyst_wtgate.sv
`timescale 1ns/1ps
module sim_hyst_wtgate;
  logic       clk = 1'b0;
  logic       rst;
  logic [3:0] din;
  logic       q;
  int checks = 0;
  int bad = 0;

  always #5 clk = ~clk;

  hyst_wtgate u0 (.clk(clk), .rst(rst), .din(din), .q(q));

  // Entry layout: {expected q, requirement number, din}
  localparam int NV = 18;
  localparam logic [7:0] VEC [NV] = '{
    {1'b0, 3'd7, 4'b0000},  // R7 idle zero
    {1'b0, 3'd5, 4'b0001},  // R5 a alone weighs 2
    {1'b0, 3'd5, 4'b0110},  // R5 b+c weigh 2
    {1'b1, 3'd3, 4'b0011},  // R3 a+b
    {1'b1, 3'd6, 4'b0001},  // R6 hold on a alone
    {1'b0, 3'd7, 4'b0000},  // R7 release
    {1'b1, 3'd3, 4'b0101},  // R3 a+c
    {1'b1, 3'd6, 4'b1000},  // R6 hold on d
    {1'b0, 3'd7, 4'b0000},  // R7
    {1'b1, 3'd3, 4'b1001},  // R3 a+d
    {1'b0, 3'd7, 4'b0000},  // R7
    {1'b1, 3'd4, 4'b1110},  // R4 b+c+d
    {1'b1, 3'd6, 4'b0100},  // R6 hold on c
    {1'b0, 3'd7, 4'b0000},  // R7
    {1'b0, 3'd5, 4'b1100},  // R5 c+d
    {1'b0, 3'd5, 4'b1010},  // R5 b+d
    {1'b1, 3'd2, 4'b1111},  // R2 all high
    {1'b0, 3'd7, 4'b0000}   // R7
  };

  task automatic chk(input logic exp, input string tag);
    checks++;
    if (q !== exp) begin
      bad++;
      $display("FAIL %s: q=%b expected %b", tag, q, exp);
    end
  endtask

  // Drive on a falling edge; return on the next falling edge
  task automatic drive(input logic [3:0] d);
    din = d;
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1;
    din = 4'b0000;
    repeat (3) @(negedge clk);
    chk(1'b0, "R1 reset state");
    rst = 1'b0;

    for (int k = 0; k < NV; k++) begin
      drive(VEC[k][3:0]);
      chk(VEC[k][7], $sformatf("R%0d vector %0d", VEC[k][6:4], k));
    end

    // R2 / R7: every pattern from a cleared state, then release
    for (int p = 1; p < 16; p++) begin
      int w;
      drive(4'b0000);
      chk(1'b0, "R7 clear before pattern");
      drive(p[3:0]);
      w = 2 * int'(p[0]) + int'(p[1]) + int'(p[2]) + int'(p[3]);
      chk(w >= 3, $sformatf("R2 pattern %0d", p));
    end

    // R6: every nonzero pattern holds after a set
    for (int p = 1; p < 16; p++) begin
      drive(4'b1111);
      drive(p[3:0]);
      chk(1'b1, $sformatf("R6 hold pattern %0d", p));
    end

    // R1: reset wins over an active set
    drive(4'b1111);
    chk(1'b1, "R8 all-ones sets");
    rst = 1'b1;
    drive(4'b1111);
    chk(1'b0, "R1 reset beats set");
    rst = 1'b0;
    drive(4'b0001);
    chk(1'b0, "R5 sub-threshold after reset");
    drive(4'b0011);
    chk(1'b1, "R3 a+b after reset");

    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    #1_000_000;
    checks++;
    bad++;
    $display("FAIL watchdog: run did not end, actual=timeout expected=done");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule